// File: doc/BRIEF.md
# Calibration Coefficient Capture Controller

This block sits in the digital back end of a sigma-delta converter and records the three coefficients used later for offset and gain correction. A host issues a command naming one calibration point: zero scale, positive full scale or negative full scale. The block then takes the next signed filter word that arrives on its valid/ready input stream.

A zero-scale capture stores the word unchanged as the offset coefficient. A full-scale capture first subtracts the stored offset at one bit wider than the word, saturates the result to the word range, and stores it as the positive or negative gain coefficient.

Each capture raises an interrupt that stays high until the host acknowledges it. Any of the three coefficients can be read back through a select input. A gain command issued before any offset has been captured since reset is refused, and the refusal is reported on an error line.

The filter-word stream has the following back-pressure rules:
- `fw_ready` is low while an interrupt is waiting for acknowledgement. During that time a presented word stays on the stream.
- When no command is armed, `fw_ready` is high and the words it accepts are discarded.
- Only the first word accepted after a command is captured.

Top module: `calcoef_capture`

## Requirements
- R1: After reset, all three coefficients read as zero, `irq` and `err` are low, and `fw_ready` is high.
- R2: After a `cmd_kind` 01 (offset) command, the first accepted filter word is stored unchanged in the offset coefficient.
- R3: After a `cmd_kind` 10 (positive gain) or 11 (negative gain) command, the first accepted word minus the stored offset is written to the chosen gain coefficient. The other coefficients keep their values.
- R4: The gain subtraction is done at 25 bits and saturates to +8388607 or -8388608 when the difference leaves the 24-bit range.
- R5: A gain command issued before any offset capture since reset is rejected. `err` goes high on the next cycle, nothing is armed, no coefficient is written and no interrupt follows.
- R6: Words accepted while no command is armed, and any word after the captured one, change no coefficient and raise no interrupt.
- R7: `irq` rises in the cycle after the capture handshake and stays high until a cycle with `irq_ack` high. The same acknowledge also clears `err`.
- R8: `fw_ready` is low whenever `irq` is high. A word held on the stream during that time is accepted only after the acknowledge.
- R9: A `cmd_kind` 00 command cancels a pending arm, so the next word is not captured.
- R10: The two gain captures may happen in either order. A later offset recapture leaves both gain coefficients unchanged.
- R11: `rd_sel` 0, 1, 2 and 3 return the offset coefficient, the positive gain coefficient, the negative gain coefficient and zero, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_kind | input | 2 | 00 cancel, 01 offset, 10 positive gain, 11 negative gain |
| fw_valid | input | 1 | Filter word valid |
| fw_ready | output | 1 | Filter word ready |
| fw_data | input | 24 | Signed filter word |
| irq | output | 1 | Capture complete interrupt, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge, also clears `err` |
| err | output | 1 | Rejected gain command |
| rd_sel | input | 2 | Coefficient read select |
| rd_data | output | 24 | Selected coefficient |

## Verification
The bench pushes both extremes of the word range through the offset subtraction. A design that wraps instead of saturating would store a gain coefficient with the wrong sign.

It issues a gain command straight after reset. A design that does not track whether an offset has been seen would write the gain register and raise `irq`.

It holds a word on the stream while an interrupt is pending. A design that ignores back-pressure would capture that word early or lose it.

It also sends a cancel command after an arm, and extra words after a capture. A design that captures more than the first word would corrupt coefficients it has already stored.

// File: rtl/calcoef_pkg.sv
package calcoef_pkg;
  typedef enum logic [1:0] {
    CAL_CANCEL  = 2'b00,
    CAL_OFFSET  = 2'b01,
    CAL_POSGAIN = 2'b10,
    CAL_NEGGAIN = 2'b11
  } cal_kind_e;

  localparam int unsigned COEF_COUNT = 3;
  localparam int unsigned IDX_OFF = 0;
  localparam int unsigned IDX_POS = 1;
  localparam int unsigned IDX_NEG = 2;
endpackage

// File: rtl/calcoef_satsub.sv
module calcoef_satsub #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] result
);
  localparam int unsigned WE = W + 1;
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [WE-1:0] wide;
  logic          ovf;

  always_comb begin
    wide = {minuend[W-1], minuend} - {subtrahend[W-1], subtrahend};
    // The two top bits disagree when the difference does not fit in W bits.
    ovf  = wide[WE-1] ^ wide[W-1];
    if (!ovf)
      result = wide[W-1:0];
    else if (wide[WE-1])
      result = MAX_NEG;
    else
      result = MAX_POS;
  end
endmodule

// File: rtl/calcoef_seq.sv
module calcoef_seq
  import calcoef_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_kind,
  input  logic                  fw_valid,
  input  logic                  irq_ack,
  output logic                  fw_ready,
  output logic                  irq,
  output logic                  err,
  output logic                  armed,
  output logic                  off_seen,
  output logic [COEF_COUNT-1:0] wr_en
);
  cal_kind_e pend_kind;
  logic      fire;
  logic      capture;
  logic      reject;
  cal_kind_e new_kind;

  assign new_kind = cal_kind_e'(cmd_kind);
  assign fw_ready = !irq;
  assign fire     = fw_valid && fw_ready;
  assign capture  = fire && armed;
  assign reject   = cmd_valid && new_kind[1] && !off_seen;

  always_comb begin
    wr_en = '0;
    if (capture) begin
      unique case (pend_kind)
        CAL_OFFSET:  wr_en[IDX_OFF] = 1'b1;
        CAL_POSGAIN: wr_en[IDX_POS] = 1'b1;
        CAL_NEGGAIN: wr_en[IDX_NEG] = 1'b1;
        default:     wr_en = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_kind <= CAL_CANCEL;
      armed     <= 1'b0;
      irq       <= 1'b0;
      err       <= 1'b0;
      off_seen  <= 1'b0;
    end else begin
      if (cmd_valid) begin
        armed     <= !(reject || new_kind == CAL_CANCEL);
        pend_kind <= new_kind;
      end else if (capture) begin
        armed <= 1'b0;
      end

      if (capture)
        irq <= 1'b1;
      else if (irq_ack)
        irq <= 1'b0;

      if (reject)
        err <= 1'b1;
      else if (irq_ack)
        err <= 1'b0;

      if (capture && pend_kind == CAL_OFFSET)
        off_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/calcoef_bank.sv
module calcoef_bank #(
  parameter int unsigned W = 24,
  parameter int unsigned N = 3,
  parameter int unsigned SW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   wr_en,
  input  logic [W-1:0]   raw_word,
  input  logic [W-1:0]   adj_word,
  input  logic [SW-1:0]  rd_sel,
  output logic [W-1:0]   coef_q [N],
  output logic [W-1:0]   rd_data
);
  for (genvar g = 0; g < N; g++) begin : g_coef
    logic [W-1:0] din;
    // Slot 0 holds the offset and takes the raw word; the others take the adjusted one.
    if (g == 0) begin : g_raw
      assign din = raw_word;
    end else begin : g_adj
      assign din = adj_word;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        coef_q[g] <= '0;
      else if (wr_en[g])
        coef_q[g] <= din;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rd_sel == SW'(i))
        rd_data = coef_q[i];
  end
endmodule

// File: rtl/calcoef_capture.sv
module calcoef_capture
  import calcoef_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [1:0]   cmd_kind,
  input  logic         fw_valid,
  output logic         fw_ready,
  input  logic [W-1:0] fw_data,
  output logic         irq,
  input  logic         irq_ack,
  output logic         err,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data
);
  localparam int unsigned N  = COEF_COUNT;
  localparam int unsigned SW = 2;

  logic [N-1:0] wr_en;
  logic         armed;
  logic         off_seen;
  logic [W-1:0] adj_word;
  logic [W-1:0] coef_q [N];

  calcoef_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .fw_valid (fw_valid),
    .irq_ack  (irq_ack),
    .fw_ready (fw_ready),
    .irq      (irq),
    .err      (err),
    .armed    (armed),
    .off_seen (off_seen),
    .wr_en    (wr_en)
  );

  calcoef_satsub #(.W(W)) u_sub (
    .minuend   (fw_data),
    .subtrahend(coef_q[IDX_OFF]),
    .result    (adj_word)
  );

  calcoef_bank #(.W(W), .N(N), .SW(SW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .raw_word(fw_data),
    .adj_word(adj_word),
    .rd_sel  (rd_sel),
    .coef_q  (coef_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/calcoef_capture_chk.sv
module calcoef_capture_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_kind,
  input logic       fw_valid,
  input logic       fw_ready,
  input logic       irq,
  input logic       irq_ack,
  input logic       err,
  input logic       armed,
  input logic       off_seen
);
  // R8
  irq_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !fw_ready);

  // R7
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R5
  early_gain_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind[1] && !off_seen) |=> (err && !armed));

  // R2
  capture_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && fw_ready && armed) |=> irq);

  // R9
  cancel_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'b00) |=> !armed);

  // R6
  idle_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && fw_ready && !armed && !irq) |=> !irq);
endmodule

bind calcoef_capture calcoef_capture_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_kind (cmd_kind),
  .fw_valid (fw_valid),
  .fw_ready (fw_ready),
  .irq      (irq),
  .irq_ack  (irq_ack),
  .err      (err),
  .armed    (armed),
  .off_seen (off_seen)
);

// File: tb/sim_calcoef_capture.sv
`timescale 1ns/1ps
module sim_calcoef_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'b00;
  logic        fw_valid = 1'b0;
  logic        fw_ready;
  logic [23:0] fw_data = '0;
  logic        irq;
  logic        irq_ack = 1'b0;
  logic        err;
  logic [1:0]  rd_sel = 2'd0;
  logic [23:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  calcoef_capture u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_data(fw_data),
    .irq(irq), .irq_ack(irq_ack), .err(err), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [23:0] data;
    logic        rej;
    logic        sat;
    logic [23:0] e_off;
    logic [23:0] e_pos;
    logic [23:0] e_neg;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 24'h0003E8, 1'b1, 1'b0, 24'h000000, 24'h000000, 24'h000000},
    '{2'd1, 24'hFFFF9C, 1'b0, 1'b0, 24'hFFFF9C, 24'h000000, 24'h000000},
    '{2'd2, 24'h001388, 1'b0, 1'b0, 24'hFFFF9C, 24'h0013EC, 24'h000000},
    '{2'd3, 24'hFFEC78, 1'b0, 1'b0, 24'hFFFF9C, 24'h0013EC, 24'hFFECDC},
    '{2'd1, 24'h7FFDA0, 1'b0, 1'b0, 24'h7FFDA0, 24'h0013EC, 24'hFFECDC},
    '{2'd3, 24'h800000, 1'b0, 1'b1, 24'h7FFDA0, 24'h0013EC, 24'h800000},
    '{2'd1, 24'h800000, 1'b0, 1'b0, 24'h800000, 24'h0013EC, 24'h800000},
    '{2'd2, 24'h7FFFFF, 1'b0, 1'b1, 24'h800000, 24'h7FFFFF, 24'h800000},
    '{2'd3, 24'hFFFFFF, 1'b0, 1'b0, 24'h800000, 24'h7FFFFF, 24'h7FFFFF},
    '{2'd1, 24'h000000, 1'b0, 1'b0, 24'h000000, 24'h7FFFFF, 24'h7FFFFF},
    '{2'd3, 24'hFFFFFF, 1'b0, 1'b0, 24'h000000, 24'h7FFFFF, 24'hFFFFFF},
    '{2'd2, 24'h00012C, 1'b0, 1'b0, 24'h000000, 24'h00012C, 24'hFFFFFF}
  };

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_coef(input logic [1:0] sel, output logic [23:0] v);
    rd_sel = sel;
    #0.5;
    v = rd_data;
  endtask

  task automatic check_coef(input string tag, input logic [1:0] sel, input logic [23:0] exp);
    logic [23:0] v;
    read_coef(sel, v);
    check(tag, v, exp);
  endtask

  task automatic send_cmd(input logic [1:0] k);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_kind = k;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_word(input logic [23:0] d);
    @(negedge clk);
    fw_valid = 1'b1;
    fw_data = d;
    @(negedge clk);
    fw_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {23'd0, irq}, 24'd0);
    check("R1 err", {23'd0, err}, 24'd0);
    check("R1 fw_ready", {23'd0, fw_ready}, 24'd1);
    check_coef("R1 off", 2'd0, 24'd0);
    check_coef("R1 pos", 2'd1, 24'd0);
    check_coef("R1 neg", 2'd2, 24'd0);
    // R11 unused select
    check_coef("R11 sel3", 2'd3, 24'd0);

    // Table walk: R2 offset, R3 gain, R4 saturation, R5 rejection, R10 ordering
    for (int i = 0; i < NV; i++) begin
      string tg;
      send_cmd(VECS[i].kind);
      send_word(VECS[i].data);
      if (VECS[i].rej) tg = "R5";
      else if (VECS[i].sat) tg = "R4";
      else if (VECS[i].kind == 2'd1) tg = "R2";
      else tg = "R3";
      check({tg, " irq"}, {23'd0, irq}, {23'd0, !VECS[i].rej});
      check({tg, " err"}, {23'd0, err}, {23'd0, VECS[i].rej});
      check_coef((VECS[i].kind == 2'd1) ? {tg, " off"} : "R10 off", 2'd0, VECS[i].e_off);
      check_coef((VECS[i].kind == 2'd2) ? {tg, " pos"} : "R10 pos", 2'd1, VECS[i].e_pos);
      check_coef((VECS[i].kind == 2'd3) ? {tg, " neg"} : "R10 neg", 2'd2, VECS[i].e_neg);
      ack();
      check("R7 ack clears irq", {23'd0, irq}, 24'd0);
      check("R7 ack clears err", {23'd0, err}, 24'd0);
    end

    // R6: a word with no command armed is discarded
    send_word(24'd77);
    check("R6 idle irq", {23'd0, irq}, 24'd0);
    check_coef("R6 idle off", 2'd0, 24'd0);

    // R9: cancel after arm
    send_cmd(2'd1);
    send_cmd(2'd0);
    send_word(24'd55);
    check("R9 irq", {23'd0, irq}, 24'd0);
    check_coef("R9 off", 2'd0, 24'd0);

    // R7 / R8: held interrupt and back-pressure
    send_cmd(2'd1);
    send_word(24'd10);
    check_coef("R2 off", 2'd0, 24'd10);
    repeat (5) @(negedge clk);
    check("R7 irq held", {23'd0, irq}, 24'd1);
    check("R8 ready low", {23'd0, fw_ready}, 24'd0);
    send_cmd(2'd2);
    fw_valid = 1'b1;
    fw_data = 24'd210;
    repeat (2) @(negedge clk);
    check_coef("R8 pos held", 2'd1, 24'h00012C);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R8 ready back", {23'd0, fw_ready}, 24'd1);
    @(negedge clk);
    fw_valid = 1'b0;
    check_coef("R8 pos taken", 2'd1, 24'd200);
    check("R8 irq again", {23'd0, irq}, 24'd1);
    ack();
    // R6: a later word is not captured
    send_word(24'd999);
    check("R6 later irq", {23'd0, irq}, 24'd0);
    check_coef("R6 later pos", 2'd1, 24'd200);

    // R5 after a fresh reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send_cmd(2'd3);
    check("R5 err", {23'd0, err}, 24'd1);
    send_word(24'h123456);
    check("R5 irq", {23'd0, irq}, 24'd0);
    check_coef("R5 neg", 2'd2, 24'd0);
    ack();
    check("R7 err cleared", {23'd0, err}, 24'd0);

    finish_run();
  end
endmodule